// File: doc/BRIEF.md
# Correlated Two-Pattern Byte-Gap Checker

This block joins two string matchers into one rule whose second string must appear a bounded number of bytes after the first. A pulse from the first matcher never reaches the rule output on its own. Instead it arms the rule and clears a byte-gap counter. Each later valid byte advances that counter. A registered window comparator then decides whether a pulse from the second matcher completes the rule.

Two constraint styles are supported. In minimum-gap mode the second string counts only once enough bytes separate it from the first. In maximum-gap mode it counts only while the separation is still small enough, and the rule disarms once that window is passed. The gap is the number of valid bytes lying strictly between the byte that completed the first string and the byte that completes the second. The limit and the mode are meant to be held steady while the rule is armed, and the block sits directly behind the matchers of one input byte stream.

Top module: `corr_gap_checker`

## Requirements
- R1: After reset `rule_hit` is 0 and the rule is disarmed, so a second-string pulse with no prior first-string pulse gives no `rule_hit`.
- R2: A first-string pulse never raises `rule_hit` by itself. It only arms the rule and clears the gap count to zero.
- R3: With `mode` = 0 (minimum gap), a second-string pulse is accepted only when the gap is at least `limit` bytes.
- R4: With `mode` = 1 (maximum gap), a second-string pulse is accepted only when the gap is at most `limit` bytes. Once the gap exceeds `limit`, the rule disarms.
- R5: An accepted second-string byte raises `rule_hit` for exactly the clock cycle after the edge that samples it.
- R6: Cycles with `byte_valid` = 0 do not advance the gap count, and both match pulses in such cycles are ignored.
- R7: A first-string pulse while the rule is armed restarts the gap count from zero.
- R8: The gap count saturates at 2^CNT_W-1 and does not wrap. With CNT_W = 8 and `limit` = 255 in minimum-gap mode, a gap of 300 bytes is accepted.
- R9: After a `rule_hit`, the rule is disarmed, and further second-string pulses are ignored until a new first-string pulse arrives.
- R10: When both pulses arrive on the same valid byte, the second is judged against the window that held before that byte and is reported if accepted. The first still re-arms the rule with a gap count of zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| byte_valid | input | 1 | A stream byte is present in this cycle |
| first_hit | input | 1 | First-string matcher fired on this byte |
| second_hit | input | 1 | Second-string matcher fired on this byte |
| mode | input | 1 | 0 = minimum gap, 1 = maximum gap |
| limit | input | CNT_W | Gap bound in bytes |
| rule_hit | output | 1 | Correlated rule matched (one-cycle pulse) |

## Verification
Restarting the gap count and accepting a second-string pulse can both occur on one byte. This happens when one byte completes both strings while the rule is armed. The bench provokes it by driving both pulses together inside a maximum-gap window. It expects a `rule_hit` judged on the old window, and it then confirms the re-arm by expecting a further hit at a gap measured from the shared byte. The same collision is also driven while the rule is disarmed, where it must produce no hit and then accept a second string on the very next byte.

// File: rtl/corr_gap_pkg.sv
// Shared types for the correlated byte-gap checker.
// Assumes: nothing beyond a one-bit mode select at the top.
package corr_gap_pkg;

    // Constraint style applied to the second-string pulse.
    typedef enum logic {
        GAP_MIN = 1'b0,
        GAP_MAX = 1'b1
    } gap_mode_e;

endpackage

// File: rtl/gap_counter.sv
// Byte-gap counter: cleared by a start pulse, advanced once per valid byte
// while armed, saturating at its all-ones value.
// Assumes: start is already qualified with byte_valid by the caller.
module gap_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_valid,
    input  logic             start,
    input  logic             armed,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_next
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // Next count: clear on start, saturating step on an armed valid byte.
    always_comb begin
        cnt_next = cnt_q;
        if (start) begin
            cnt_next = '0;
        end else if (armed && byte_valid && (cnt_q != CNT_MAX)) begin
            cnt_next = cnt_q + 1'b1;
        end
    end

    // Count register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_next;
        end
    end

    // R7
    restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (cnt_q == '0));

    // R8
    cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt_q == CNT_MAX) && !start) |=> (cnt_q == CNT_MAX));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_valid |=> $stable(cnt_q));

endmodule

// File: rtl/gap_window.sv
// Window comparator: judges the next count against the limit and registers
// the verdict, so the registered gate always describes the current count.
// Assumes: limit and mode are steady while the rule is armed.
module gap_window
    import corr_gap_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  gap_mode_e        mode,
    input  logic [CNT_W-1:0] limit,
    input  logic [CNT_W-1:0] cnt_next,
    output logic             in_win_next,
    output logic             gate_q
);

    // Compare the upcoming count against the bound for the selected style.
    always_comb begin
        if (mode == GAP_MIN) begin
            in_win_next = (cnt_next >= limit);
        end else begin
            in_win_next = (cnt_next <= limit);
        end
    end

    // Register the verdict alongside the count it was computed from.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q <= 1'b0;
        end else begin
            gate_q <= in_win_next;
        end
    end

endmodule

// File: rtl/arm_ctrl.sv
// Arming control: qualifies match pulses with byte_valid, keeps the armed
// flag, accepts the second string through the gate and registers the hit.
// Assumes: gate_q reflects the current count; in_win_next reflects the next.
module arm_ctrl
    import corr_gap_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      byte_valid,
    input  logic      first_hit,
    input  logic      second_hit,
    input  gap_mode_e mode,
    input  logic      gate_q,
    input  logic      in_win_next,
    output logic      start,
    output logic      armed,
    output logic      rule_hit
);

    logic accept;
    logic armed_next;

    // Qualify match pulses with the byte strobe.
    always_comb begin
        start  = byte_valid && first_hit;
        accept = byte_valid && second_hit && armed && gate_q;
    end

    // Next armed state: start wins, then a hit or an expired window disarms.
    always_comb begin
        armed_next = armed;
        if (start) begin
            armed_next = 1'b1;
        end else if (accept) begin
            armed_next = 1'b0;
        end else if ((mode == GAP_MAX) && !in_win_next) begin
            armed_next = 1'b0;
        end
    end

    // Armed flag and registered rule output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed    <= 1'b0;
            rule_hit <= 1'b0;
        end else begin
            armed    <= armed_next;
            rule_hit <= accept;
        end
    end

    // R9
    hit_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !start) |=> !armed);

    // R2
    hit_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rule_hit |-> $past(byte_valid && second_hit));

    // R10
    collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && accept) |=> (armed && rule_hit));

endmodule

// File: rtl/corr_gap_checker.sv
// Correlated two-pattern byte-gap checker (top). The first-string pulse arms
// the rule and clears the gap counter. The second-string pulse completes the
// rule only inside the gap window chosen by mode and limit.
// Assumes: one byte per cycle at most; limit and mode steady while armed.
module corr_gap_checker
    import corr_gap_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_valid,
    input  logic             first_hit,
    input  logic             second_hit,
    input  logic             mode,
    input  logic [CNT_W-1:0] limit,
    output logic             rule_hit
);

    gap_mode_e        mode_e;
    logic             start;
    logic             armed;
    logic             gate_q;
    logic             in_win_next;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_next;

    // Map the raw mode pin onto the shared enum.
    always_comb begin
        mode_e = gap_mode_e'(mode);
    end

    gap_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_valid (byte_valid),
        .start      (start),
        .armed      (armed),
        .cnt_q      (cnt_q),
        .cnt_next   (cnt_next)
    );

    gap_window #(.CNT_W(CNT_W)) u_win (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (mode_e),
        .limit       (limit),
        .cnt_next    (cnt_next),
        .in_win_next (in_win_next),
        .gate_q      (gate_q)
    );

    arm_ctrl u_arm (
        .clk         (clk),
        .rst_n       (rst_n),
        .byte_valid  (byte_valid),
        .first_hit   (first_hit),
        .second_hit  (second_hit),
        .mode        (mode_e),
        .gate_q      (gate_q),
        .in_win_next (in_win_next),
        .start       (start),
        .armed       (armed),
        .rule_hit    (rule_hit)
    );

    // R4
    within_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(armed && (mode_e == GAP_MAX) && (cnt_q > limit)));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!rule_hit && !armed));

endmodule

// File: tb/tb_corr_gap_checker.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_corr_gap_checker;

    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             byte_valid = 1'b0;
    logic             first_hit = 1'b0;
    logic             second_hit = 1'b0;
    logic             mode = 1'b0;
    logic [CNT_W-1:0] limit = '0;
    logic             rule_hit;

    int checks = 0;
    int errors = 0;

    corr_gap_checker #(.CNT_W(CNT_W)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_valid (byte_valid),
        .first_hit  (first_hit),
        .second_hit (second_hit),
        .mode       (mode),
        .limit      (limit),
        .rule_hit   (rule_hit)
    );

    always #5 clk = ~clk;

    // Compare and count one result.
    task automatic chk(input logic exp, input string tag);
        checks++;
        if (rule_hit !== exp) begin
            errors++;
            $display("FAIL %s: rule_hit=%0b expected %0b", tag, rule_hit, exp);
        end
    endtask

    // Drive one cycle, then settle 2 ns past the edge that samples it.
    task automatic step(input logic v, input logic f, input logic s);
        byte_valid = v;
        first_hit  = f;
        second_hit = s;
        @(posedge clk);
        #2;
        byte_valid = 1'b0;
        first_hit  = 1'b0;
        second_hit = 1'b0;
    endtask

    // Feed n valid bytes carrying no match.
    task automatic gap(input int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b0);
    endtask

    task automatic do_reset(input logic m, input logic [CNT_W-1:0] lim);
        rst_n = 1'b0;
        mode  = m;
        limit = lim;
        step(1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset(1'b1, 8'd20);
        chk(1'b0, "R1 idle after reset");
        step(1'b1, 1'b0, 1'b1);
        chk(1'b0, "R1 second without first");
    endtask

    task automatic t_first_only();
        do_reset(1'b1, 8'd10);
        step(1'b1, 1'b1, 1'b0);
        chk(1'b0, "R2 first alone");
        gap(3);
        chk(1'b0, "R2 first alone later");
    endtask

    task automatic t_min_gap();
        do_reset(1'b0, 8'd4);
        step(1'b1, 1'b1, 1'b0);
        gap(3);
        step(1'b1, 1'b0, 1'b1);
        chk(1'b0, "R3 gap 3 below 4");
        step(1'b1, 1'b0, 1'b1);
        chk(1'b1, "R3 gap 4 accepted");
        step(1'b1, 1'b0, 1'b0);
        chk(1'b0, "R5 single-cycle pulse");
        step(1'b1, 1'b0, 1'b1);
        chk(1'b0, "R9 disarmed after hit");
    endtask

    task automatic t_max_gap();
        do_reset(1'b1, 8'd3);
        step(1'b1, 1'b1, 1'b0);
        gap(3);
        step(1'b1, 1'b0, 1'b1);
        chk(1'b1, "R4 gap 3 at bound");
        step(1'b1, 1'b1, 1'b0);
        gap(4);
        step(1'b1, 1'b0, 1'b1);
        chk(1'b0, "R4 gap 4 past bound");
        step(1'b1, 1'b1, 1'b0);
        step(1'b1, 1'b0, 1'b1);
        chk(1'b1, "R4 gap 0 accepted");
    endtask

    task automatic t_invalid();
        do_reset(1'b1, 8'd5);
        step(1'b0, 1'b1, 1'b0);
        step(1'b1, 1'b0, 1'b1);
        chk(1'b0, "R6 invalid first ignored");
        do_reset(1'b0, 8'd2);
        step(1'b1, 1'b1, 1'b0);
        for (int i = 0; i < 5; i++) begin
            step(1'b0, 1'b0, 1'b1);
            chk(1'b0, "R6 invalid second ignored");
        end
        gap(1);
        step(1'b1, 1'b0, 1'b1);
        chk(1'b0, "R6 invalid bytes not counted");
        step(1'b1, 1'b0, 1'b1);
        chk(1'b1, "R6 gap 2 reached");
    endtask

    task automatic t_restart();
        do_reset(1'b1, 8'd3);
        step(1'b1, 1'b1, 1'b0);
        gap(2);
        step(1'b1, 1'b1, 1'b0);
        gap(3);
        step(1'b1, 1'b0, 1'b1);
        chk(1'b1, "R7 max-gap window restarted");
        do_reset(1'b0, 8'd3);
        step(1'b1, 1'b1, 1'b0);
        gap(2);
        step(1'b1, 1'b1, 1'b0);
        gap(1);
        step(1'b1, 1'b0, 1'b1);
        chk(1'b0, "R7 min-gap count restarted");
    endtask

    task automatic t_saturate();
        do_reset(1'b0, 8'd255);
        step(1'b1, 1'b1, 1'b0);
        gap(254);
        step(1'b1, 1'b0, 1'b1);
        chk(1'b0, "R8 gap 254 below 255");
        step(1'b1, 1'b0, 1'b1);
        chk(1'b1, "R8 gap 255 accepted");
        step(1'b1, 1'b1, 1'b0);
        gap(300);
        step(1'b1, 1'b0, 1'b1);
        chk(1'b1, "R8 gap 300 saturated");
    endtask

    task automatic t_collide();
        do_reset(1'b1, 8'd2);
        step(1'b1, 1'b1, 1'b0);
        gap(1);
        step(1'b1, 1'b1, 1'b1);
        chk(1'b1, "R10 collision judged on old window");
        gap(2);
        step(1'b1, 1'b0, 1'b1);
        chk(1'b1, "R10 re-armed from shared byte");
        do_reset(1'b1, 8'd2);
        step(1'b1, 1'b1, 1'b1);
        chk(1'b0, "R10 collision while disarmed");
        step(1'b1, 1'b0, 1'b1);
        chk(1'b1, "R10 armed by collision");
    endtask

    initial begin
        t_reset();
        t_first_only();
        t_min_gap();
        t_max_gap();
        t_invalid();
        t_restart();
        t_saturate();
        t_collide();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #1000000;
        checks++;
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule